// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic and logic stage of a processor pipeline. Each cycle it takes two operands and a 4-bit operation code. It produces a result, a result write-enable and the next value of a four-bit condition flag set (negative, zero, carry, overflow), which it holds in a register. The arithmetic operations are add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. The logical operations are AND and XOR. Four flag-only variants (compare, compare-negative, bit-test and equality-test) compute the same values as subtract, add, AND and XOR, but never request a register write.

Every subtraction runs on the single adder as `X + ~Y + carry_in`. The carry flag after a subtract or compare is therefore the adder's carry-out. It reads as "no borrow occurred" and is not a borrow flag. The logical operations take their carry from a shifter carry input supplied by the stage in front, and they leave overflow unchanged. Chaining add-with-carry or subtract-with-carry after a flag-setting first word gives multiword arithmetic. The operand shifter, the register file and instruction decode are outside this block.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives result A+B, opcode 1 (add with carry) gives A+B+C, and opcode 9 (compare-negative) computes A+B. Carry is bit WIDTH of the unbounded sum, so all-ones + 1 gives result 0 with C=1.
- R2: Opcode 2 (subtract) and opcode 8 (compare) compute A-B. Opcode 3 (subtract with carry) computes A-B-(1-C), opcode 4 (reverse subtract) computes B-A, and opcode 5 (reverse subtract with carry) computes B-A-(1-C). C is 1 when the true difference is not negative (no borrow), so 0-0 gives C=1 and 1-2 gives C=0.
- R3: For opcodes 0 to 5, 8 and 9, V is 1 exactly when the signed two's-complement value of the exact operation lies outside the WIDTH-bit signed range.
- R4: The flag vector is {N,Z,C,V} with N at bit 3 and V at bit 0. On an update, N equals the result's top bit, and Z is 1 exactly when every result bit is 0.
- R5: Opcodes 6 and 10 give A AND B, and opcodes 7 and 11 give A XOR B. On an update after any of these four, C takes the `shift_carry` input and V keeps its previous value.
- R6: Opcodes 8 to 11 drive their computed value on `result` with `result_we` low, and they load the flag register on every clock edge whatever `set_flags` is.
- R7: Opcodes 0 to 7 set `result_we` high. They load the flag register only when `set_flags` is 1. Otherwise `flags_q` holds its value and `flags_next` equals `flags_q`.
- R8: Opcodes 12 to 15 are reserved. They give `result` 0 and `result_we` low, and they leave the flags unchanged even when `set_flags` is 1.
- R9: An active-low `rst_n` clears all four flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (after the shifter) |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update for opcodes 0 to 7 |
| shift_carry | input | 1 | Carry from the operand shifter, used by logical operations |
| result | output | WIDTH | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_next | output | 4 | Flag value loaded at the next edge, {N,Z,C,V} |
| flags_q | output | 4 | Current registered flags, {N,Z,C,V} |

## Verification
The bound checker checks the following on every cycle:
- N and Z follow the result.
- Logical operations pass the shifter carry through and keep V.
- The flag-only variants never raise the write-enable and always load the register.
- Flags hold when no update is requested.
- Reserved codes are inert.

Only the bench scenarios can show the arithmetic itself: the carry as not-borrow on the subtract forms, the extra unit that add-with-carry and subtract-with-carry take from the incoming C, and the signed overflow boundaries. To cover these, the bench sweeps every operand pair of a 4-bit instance under three prior flag states and compares each output with integer arithmetic.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_RSC = 4'd5,
    OP_AND = 4'd6,
    OP_XOR = 4'd7,
    OP_CMP = 4'd8,
    OP_CMN = 4'd9,
    OP_TST = 4'd10,
    OP_TEQ = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op <= 4'd5) || (op == 4'd8) || (op == 4'd9);
  endfunction

  function automatic logic op_is_logic(input logic [3:0] op);
    return (op == 4'd6) || (op == 4'd7) || (op == 4'd10) || (op == 4'd11);
  endfunction

  function automatic logic op_is_flag_only(input logic [3:0] op);
    return (op >= 4'd8) && (op <= 4'd11);
  endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       op,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);
  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] x_opnd;
  logic [WIDTH-1:0] y_opnd;
  logic             cin;
  logic [SW-1:0]    full;

  always_comb begin
    x_opnd = a;
    y_opnd = b;
    cin    = 1'b0;
    case (op)
      OP_ADD, OP_CMN: begin x_opnd = a; y_opnd = b;  cin = 1'b0; end
      OP_ADC:         begin x_opnd = a; y_opnd = b;  cin = c_in; end
      OP_SUB, OP_CMP: begin x_opnd = a; y_opnd = ~b; cin = 1'b1; end
      OP_SBC:         begin x_opnd = a; y_opnd = ~b; cin = c_in; end
      OP_RSB:         begin x_opnd = b; y_opnd = ~a; cin = 1'b1; end
      OP_RSC:         begin x_opnd = b; y_opnd = ~a; cin = c_in; end
      default:        begin x_opnd = a; y_opnd = b;  cin = 1'b0; end
    endcase
  end

  always_comb begin
    full  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{WIDTH{1'b0}}, cin};
    sum   = full[WIDTH-1:0];
    c_out = full[WIDTH];
    v_out = (x_opnd[WIDTH-1] == y_opnd[WIDTH-1]) &&
            (full[WIDTH-1] != x_opnd[WIDTH-1]);
  end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: out = a & b;
      OP_XOR, OP_TEQ: out = a ^ b;
      default:        out = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] res,
  input  logic             arith,
  input  logic             add_c,
  input  logic             add_v,
  input  logic             shift_carry,
  input  logic             update,
  output nzcv_t            flags_d,
  output nzcv_t            flags_r
);
  nzcv_t computed;

  always_comb begin
    computed.n = res[WIDTH-1];
    computed.z = (res == '0);
    computed.c = arith ? add_c : shift_carry;
    computed.v = arith ? add_v : flags_r.v;
    flags_d    = update ? computed : flags_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_r <= '0;
    end else if (update) begin
      flags_r <= flags_d;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_next,
  output logic [3:0]       flags_q
);
  logic [WIDTH-1:0] add_sum;
  logic [WIDTH-1:0] log_out;
  logic             add_c;
  logic             add_v;
  logic             is_arith;
  logic             is_logic;
  logic             is_valid;
  logic             upd;
  nzcv_t            f_d;
  nzcv_t            f_r;

  always_comb begin
    is_arith  = op_is_arith(opcode);
    is_logic  = op_is_logic(opcode);
    is_valid  = is_arith || is_logic;
    upd       = op_is_flag_only(opcode) || (set_flags && is_valid);
    result_we = (opcode <= 4'd7);
    if (is_arith)      result = add_sum;
    else if (is_logic) result = log_out;
    else               result = '0;
  end

  flag_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a(opnd_a), .b(opnd_b), .op(opcode), .c_in(f_r.c),
    .sum(add_sum), .c_out(add_c), .v_out(add_v)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .op(opcode), .out(log_out)
  );

  flag_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .res(result), .arith(is_arith),
    .add_c(add_c), .add_v(add_v), .shift_carry(shift_carry),
    .update(upd), .flags_d(f_d), .flags_r(f_r)
  );

  assign flags_next = f_d;
  assign flags_q    = f_r;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       opcode,
  input logic             set_flags,
  input logic             shift_carry,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic [3:0]       flags_next,
  input logic [3:0]       flags_q
);
  logic flag_only;
  logic logical;
  logic loads;

  assign flag_only = (opcode >= 4'd8) && (opcode <= 4'd11);
  assign logical   = (opcode == 4'd6) || (opcode == 4'd7) ||
                     (opcode == 4'd10) || (opcode == 4'd11);
  assign loads     = flag_only || (set_flags && (opcode <= 4'd11));

  p_n_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loads |-> (flags_next[3] == result[WIDTH-1]));

  p_z_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loads |-> (flags_next[2] == (result == '0)));

  p_logic_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (logical && loads) |-> (flags_next[1] == shift_carry && flags_next[0] == flags_q[0]));

  p_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_only |-> !result_we);

  p_cmp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_only |=> (flags_q == $past(flags_next)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !loads |=> $stable(flags_q));

  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 4'd12) |-> (result == '0 && !result_we && flags_next == flags_q));
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .opcode(opcode), .set_flags(set_flags), .shift_carry(shift_carry),
  .result(result), .result_we(result_we), .flags_next(flags_next),
  .flags_q(flags_q)
);

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opnd_a, opnd_b;
  logic [3:0]   opcode;
  logic         set_flags, shift_carry;
  logic [W-1:0] result;
  logic         result_we;
  logic [3:0]   flags_next, flags_q;

  int vecs = 0;
  int errs = 0;

  flag_alu #(.WIDTH(W)) u_flag_alu (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .opcode(opcode), .set_flags(set_flags), .shift_carry(shift_carry),
    .result(result), .result_we(result_we), .flags_next(flags_next),
    .flags_q(flags_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0h expected=%0h",
               req, opcode, opnd_a, opnd_b, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x >= 8) ? x - 16 : x;
  endfunction

  // prior flag states: 0 -> 0110, 1 -> 1000, 2 -> 1001
  task automatic setup(input int s);
    @(negedge clk);
    set_flags = 1'b0; shift_carry = 1'b0;
    case (s)
      0: begin opcode = 4'd8; opnd_a = 0; opnd_b = 0; end
      1: begin opcode = 4'd8; opnd_a = 0; opnd_b = 1; end
      default: begin opcode = 4'd9; opnd_a = 7; opnd_b = 1; end
    endcase
    @(posedge clk); #1;
    check("R6 compare loads flags", flags_q, (s == 0) ? 4'b0110 : (s == 1) ? 4'b1000 : 4'b1001);
  endtask

  task automatic run_vec(input int op, input int a, input int b, input bit sf,
                         input bit sc, input logic [3:0] prior);
    int s, ex_res, ex_c, ex_v;
    bit cf, upd, arith;
    logic [3:0] ex_next;
    cf = prior[1];
    ex_res = 0; ex_c = 0; ex_v = prior[0]; arith = 1'b0;
    case (op)
      0, 1, 9: begin
        arith = 1'b1;
        s = a + b + ((op == 1) ? int'(cf) : 0);
        ex_res = s & 15; ex_c = (s > 15);
        s = sgn(a) + sgn(b) + ((op == 1) ? int'(cf) : 0);
        ex_v = (s > 7 || s < -8);
      end
      2, 3, 4, 5, 8: begin
        arith = 1'b1;
        if (op == 4 || op == 5) s = b - a; else s = a - b;
        if (op == 3 || op == 5) s = s - (cf ? 0 : 1);
        ex_res = s & 15; ex_c = (s >= 0);
        if (op == 4 || op == 5) s = sgn(b) - sgn(a); else s = sgn(a) - sgn(b);
        if (op == 3 || op == 5) s = s - (cf ? 0 : 1);
        ex_v = (s > 7 || s < -8);
      end
      6, 10: begin ex_res = a & b; ex_c = sc; end
      7, 11: begin ex_res = a ^ b; ex_c = sc; end
      default: ex_res = 0;
    endcase
    upd = (op >= 8 && op <= 11) || (sf && op <= 11);
    ex_next = upd ? {ex_res[3], ex_res == 0, ex_c[0], ex_v[0]} : prior;
    @(negedge clk);
    opcode = op[3:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
    set_flags = sf; shift_carry = sc;
    #1;
    if (op >= 12) begin
      check("R8 reserved result", result, 0);
      check("R8 reserved flags", flags_next, prior);
    end else if (arith) begin
      check(op == 0 || op == 1 || op == 9 ? "R1 add result" : "R2 sub result", result, ex_res);
    end else begin
      check("R5 logic result", result, ex_res);
    end
    check(op >= 8 ? "R6 no write" : "R7 write enable", result_we, op <= 7);
    if (arith && upd)
      check(op == 0 || op == 1 || op == 9 ? "R1 R3 R4 add flags" : "R2 R3 R4 sub flags",
            flags_next, ex_next);
    else if (upd)
      check("R4 R5 logic flags", flags_next, ex_next);
    else
      check("R7 hold next", flags_next, ex_next);
    @(posedge clk); #1;
    check(upd ? "R6 R7 flags loaded" : "R7 flags held", flags_q, ex_next);
  endtask

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 4'd0; opnd_a = '0; opnd_b = '0;
    set_flags = 1'b0; shift_carry = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset flags", flags_q, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            setup(s);
            run_vec(op, a, b, ((a + b + s) % 2) == 0, ((a ^ b ^ op) & 1) == 1,
                    (s == 0) ? 4'b0110 : (s == 1) ? 4'b1000 : 4'b1001);
          end

    // R2 directed: 0-0 gives no borrow, 1-2 gives borrow
    setup(1);
    run_vec(2, 0, 0, 1'b1, 1'b0, 4'b1000);
    check("R2 zero minus zero carry", flags_q[1], 1);
    run_vec(2, 1, 2, 1'b1, 1'b0, 4'b0110);
    check("R2 one minus two carry", flags_q[1], 0);

    // R9 asynchronous reset mid-run
    setup(2);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R9 async reset clears flags", flags_q, 0);
    @(negedge clk) rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule